// File: doc/BRIEF.md
# Depth-First Transfer Queue Walker

The walker steps through a linked schedule of transfer descriptors held in small internal tables. There are two kinds of object. A queue head carries a vertical pointer to a chain of descriptors and a horizontal pointer to the next object. A descriptor carries an active flag, a short-packet-detect flag, a depth-first flag, a requested length and a link pointer. A pulse on `frame_start` starts a walk at `start_ptr`. For each active descriptor the walker hands one command to an abstract transaction engine on a valid/ready stream. It then waits for the completion beat, which carries the number of bytes actually moved. Only one descriptor is ever outstanding.

Descriptors in a queue's vertical chain run strictly in order. After each one completes, the queue's vertical pointer moves past it, so a walk that stops early picks up at the first unexecuted descriptor on the next visit. A short completion on a descriptor that has detection enabled abandons the rest of the chain and sends the walk to the queue's horizontal pointer. A typical use is a setup descriptor and a run of data descriptors in the vertical chain, with one status descriptor on the horizontal pointer, so that a short read goes straight to status. A `budget_ok` input that is sampled only before each issue lets a frame end at a descriptor boundary.

Both streams follow the same rule. A beat transfers on a rising edge where valid and ready are both high. `exec_valid` and its payload hold steady until `exec_ready` is seen, and the engine may stall for any number of cycles. `cmp_ready` is high only while a command is outstanding. The configuration write port accepts beats only while no walk is in progress.

Top module: `qw_queue_walker`

## Requirements
- R1: After reset `exec_valid`, `cmp_ready`, `busy` and `frame_done` are low, `cfg_ready` is high, and every descriptor is inactive.
- R2: A configuration beat is taken when `cfg_valid` and `cfg_ready` are both high, and `cfg_ready` is low while `busy`. A pointer is {terminate bit 5, queue-head flag bit 4, index bits 3:0}. When `cfg_kind` is 0, the beat writes a descriptor as {active 15, short-detect 14, depth-first 13, requested length 12:6, link 5:0}. When `cfg_kind` is 1, it writes a queue head as {vertical pointer 11:6, horizontal pointer 5:0}.
- R3: Descriptors of a vertical chain are issued in link order, with at most one command outstanding. `exec_valid` holds with a stable payload until accepted, and `exec_len` carries the descriptor's requested length.
- R4: A completed vertical descriptor with its depth-first flag set and no short condition is followed by the next descriptor of the same chain. With the flag clear, the walk moves to the horizontal pointer, and the next frame continues the chain.
- R5: A completion with short-detect set and `cmp_len` below the requested length terminates the queue's vertical pointer and moves the walk to the horizontal pointer. With short-detect clear, a short completion does not stop the chain.
- R6: A queue head whose vertical pointer is terminated, has the queue-head flag set, or names an inactive descriptor is passed over through its horizontal pointer.
- R7: `budget_ok` is checked only before a command is issued. When it is low, the walk ends with a `frame_done` pulse, and the next frame resumes at the first unexecuted descriptor.
- R8: A completed descriptor becomes inactive and is never issued again.
- R9: A descriptor reached horizontally is issued if active, and its link is then followed. Reaching a terminated pointer ends the walk with a one-cycle `frame_done` pulse.
- R10: `frame_start` has no effect while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration beat valid |
| cfg_ready | output | 1 | Configuration beat accepted (idle only) |
| cfg_kind | input | 1 | 0 = descriptor, 1 = queue head |
| cfg_idx | input | 4 | Table index written |
| cfg_data | input | 16 | Packed descriptor or queue-head word |
| frame_start | input | 1 | Start a walk at `start_ptr` |
| start_ptr | input | 6 | First schedule pointer of the frame |
| budget_ok | input | 1 | Frame time remains for another descriptor |
| busy | output | 1 | Walk in progress |
| frame_done | output | 1 | One-cycle pulse when a walk ends |
| exec_valid | output | 1 | Command to the transaction engine valid |
| exec_ready | input | 1 | Engine accepts the command |
| exec_td | output | 4 | Descriptor index of the command |
| exec_len | output | 7 | Requested byte count |
| exec_queued | output | 1 | Command belongs to a vertical chain |
| cmp_valid | input | 1 | Completion beat valid |
| cmp_ready | output | 1 | Walker waiting for a completion |
| cmp_len | input | 7 | Bytes actually transferred |

## Verification
A wrong vertical pointer or active flag does not stay hidden. It shows at the next issue as an out-of-order, repeated or missing `exec_td`, often only one frame later, when a resumed walk starts at the wrong descriptor. For that reason the bench always runs a second frame after each scenario and expects the exact remaining sequence, or silence. A wrong decision on short or depth shows within one command, because the index issued next is the status descriptor instead of the next data descriptor, or the reverse.

// File: rtl/qw_pkg.sv
package qw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } walk_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qw_td_store.sv
module qw_td_store #(
  parameter int NTD  = 16,
  parameter int TIW  = 4,
  parameter int LENW = 7,
  parameter int PW   = 6,
  localparam int CW  = PW + LENW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TIW-1:0]  wr_idx,
  input  logic [CW-1:0]   wr_data,
  input  logic            clr_en,
  input  logic [TIW-1:0]  clr_idx,
  input  logic [TIW-1:0]  rd_idx,
  output logic            rd_active,
  output logic            rd_spd,
  output logic            rd_depth,
  output logic [LENW-1:0] rd_maxlen,
  output logic [PW-1:0]   rd_link
);
  logic            act_q   [NTD];
  logic            spd_q   [NTD];
  logic            dep_q   [NTD];
  logic [LENW-1:0] len_q   [NTD];
  logic [PW-1:0]   link_q  [NTD];

  for (genvar g = 0; g < NTD; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[g]  <= 1'b0;
        spd_q[g]  <= 1'b0;
        dep_q[g]  <= 1'b0;
        len_q[g]  <= '0;
        link_q[g] <= {1'b1, {(PW-1){1'b0}}};
      end else if (wr_en && (wr_idx == TIW'(g))) begin
        act_q[g]  <= wr_data[CW-1];
        spd_q[g]  <= wr_data[CW-2];
        dep_q[g]  <= wr_data[CW-3];
        len_q[g]  <= wr_data[PW +: LENW];
        link_q[g] <= wr_data[PW-1:0];
      end else if (clr_en && (clr_idx == TIW'(g))) begin
        act_q[g] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_active = act_q[rd_idx];
    rd_spd    = spd_q[rd_idx];
    rd_depth  = dep_q[rd_idx];
    rd_maxlen = len_q[rd_idx];
    rd_link   = link_q[rd_idx];
  end
endmodule

// File: rtl/qw_qh_store.sv
module qw_qh_store #(
  parameter int NQH = 4,
  parameter int QIW = 2,
  parameter int PW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [QIW-1:0] wr_idx,
  input  logic [2*PW-1:0] wr_data,
  input  logic           upd_en,
  input  logic [QIW-1:0] upd_idx,
  input  logic [PW-1:0]  upd_vptr,
  input  logic [QIW-1:0] rd_idx,
  output logic [PW-1:0]  rd_vptr,
  output logic [PW-1:0]  rd_hptr
);
  localparam logic [PW-1:0] TERM_PTR = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] vptr_q [NQH];
  logic [PW-1:0] hptr_q [NQH];

  for (genvar g = 0; g < NQH; g++) begin : g_qh
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vptr_q[g] <= TERM_PTR;
        hptr_q[g] <= TERM_PTR;
      end else if (wr_en && (wr_idx == QIW'(g))) begin
        vptr_q[g] <= wr_data[2*PW-1:PW];
        hptr_q[g] <= wr_data[PW-1:0];
      end else if (upd_en && (upd_idx == QIW'(g))) begin
        vptr_q[g] <= upd_vptr;
      end
    end
  end

  assign rd_vptr = vptr_q[rd_idx];
  assign rd_hptr = hptr_q[rd_idx];
endmodule

// File: rtl/qw_walk_fsm.sv
module qw_walk_fsm
  import qw_pkg::*;
#(
  parameter int TIW  = 4,
  parameter int QIW  = 2,
  parameter int LENW = 7,
  parameter int PW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [PW-1:0]   start_ptr,
  input  logic            budget_ok,
  output logic            busy,
  output logic            frame_done,
  output logic            exec_valid,
  input  logic            exec_ready,
  output logic [TIW-1:0]  exec_td,
  output logic            exec_queued,
  input  logic            cmp_valid,
  output logic            cmp_ready,
  input  logic [LENW-1:0] cmp_len,
  output logic [QIW-1:0]  qh_rd_idx,
  input  logic [PW-1:0]   qh_vptr,
  input  logic [PW-1:0]   qh_hptr,
  output logic            qh_upd_en,
  output logic [PW-1:0]   qh_upd_vptr,
  output logic [TIW-1:0]  td_rd_idx,
  input  logic            td_active,
  input  logic            td_spd,
  input  logic            td_depth,
  input  logic [LENW-1:0] td_maxlen,
  input  logic [PW-1:0]   td_link,
  output logic            td_clr_en
);
  localparam int TERM_BIT = PW - 1;
  localparam int QH_BIT   = PW - 2;
  localparam logic [PW-1:0] TERM_PTR = {1'b1, {(PW-1){1'b0}}};

  walk_st_e       state_q, state_d;
  logic [PW-1:0]  cur_q, cur_d;
  logic           inq_q, inq_d;
  logic [QIW-1:0] qsel_q, qsel_d;
  logic [TIW-1:0] tsel_q, tsel_d;
  logic           done_d, done_q;
  logic           head_ok;
  logic           short_pkt;

  assign head_ok   = !qh_vptr[TERM_BIT] && !qh_vptr[QH_BIT];
  assign short_pkt = td_spd && (cmp_len < td_maxlen);

  always_comb begin
    qh_rd_idx = (state_q == ST_FETCH) ? cur_q[QIW-1:0] : qsel_q;
    if (state_q == ST_FETCH) begin
      td_rd_idx = cur_q[QH_BIT] ? qh_vptr[TIW-1:0] : cur_q[TIW-1:0];
    end else begin
      td_rd_idx = tsel_q;
    end
  end

  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    inq_d       = inq_q;
    qsel_d      = qsel_q;
    tsel_d      = tsel_q;
    done_d      = 1'b0;
    td_clr_en   = 1'b0;
    qh_upd_en   = 1'b0;
    qh_upd_vptr = td_link;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d = ST_FETCH;
          cur_d   = start_ptr;
        end
      end
      ST_FETCH: begin
        if (cur_q[TERM_BIT]) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (cur_q[QH_BIT]) begin
          if (head_ok && td_active) begin
            if (budget_ok) begin
              state_d = ST_ISSUE;
              inq_d   = 1'b1;
              qsel_d  = cur_q[QIW-1:0];
              tsel_d  = qh_vptr[TIW-1:0];
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cur_d = qh_hptr;
          end
        end else begin
          if (td_active) begin
            if (budget_ok) begin
              state_d = ST_ISSUE;
              inq_d   = 1'b0;
              tsel_d  = cur_q[TIW-1:0];
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end else begin
            cur_d = td_link;
          end
        end
      end
      ST_ISSUE: begin
        if (exec_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cmp_valid) begin
          state_d   = ST_FETCH;
          td_clr_en = 1'b1;
          if (inq_q) begin
            qh_upd_en   = 1'b1;
            qh_upd_vptr = short_pkt ? TERM_PTR : td_link;
            if (short_pkt || !td_depth) cur_d = qh_hptr;
          end else begin
            cur_d = td_link;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= TERM_PTR;
      inq_q   <= 1'b0;
      qsel_q  <= '0;
      tsel_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      inq_q   <= inq_d;
      qsel_q  <= qsel_d;
      tsel_q  <= tsel_d;
      done_q  <= done_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign frame_done  = done_q;
  assign exec_valid  = (state_q == ST_ISSUE);
  assign exec_td     = tsel_q;
  assign exec_queued = inq_q;
  assign cmp_ready   = (state_q == ST_WAIT);
endmodule

// File: rtl/qw_queue_walker.sv
module qw_queue_walker
  import qw_pkg::*;
#(
  parameter int NTD  = 16,
  parameter int NQH  = 4,
  parameter int LENW = 7,
  localparam int TIW = (NTD > 1) ? $clog2(NTD) : 1,
  localparam int QIW = (NQH > 1) ? $clog2(NQH) : 1,
  localparam int PIW = max2(TIW, QIW),
  localparam int PW  = PIW + 2,
  localparam int CW  = max2(PW + LENW + 3, 2 * PW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic            cfg_kind,
  input  logic [PIW-1:0]  cfg_idx,
  input  logic [CW-1:0]   cfg_data,
  input  logic            frame_start,
  input  logic [PW-1:0]   start_ptr,
  input  logic            budget_ok,
  output logic            busy,
  output logic            frame_done,
  output logic            exec_valid,
  input  logic            exec_ready,
  output logic [TIW-1:0]  exec_td,
  output logic [LENW-1:0] exec_len,
  output logic            exec_queued,
  input  logic            cmp_valid,
  output logic            cmp_ready,
  input  logic [LENW-1:0] cmp_len
);
  logic            cfg_fire;
  logic [QIW-1:0]  qh_rd_idx;
  logic [PW-1:0]   qh_vptr, qh_hptr, qh_upd_vptr;
  logic            qh_upd_en;
  logic [TIW-1:0]  td_rd_idx;
  logic            td_active, td_spd, td_depth, td_clr_en;
  logic [LENW-1:0] td_maxlen;
  logic [PW-1:0]   td_link;

  assign cfg_ready = !busy;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign exec_len  = td_maxlen;

  qw_td_store #(.NTD(NTD), .TIW(TIW), .LENW(LENW), .PW(PW)) u_td (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_fire && !cfg_kind),
    .wr_idx    (cfg_idx[TIW-1:0]),
    .wr_data   (cfg_data[PW+LENW+2:0]),
    .clr_en    (td_clr_en),
    .clr_idx   (exec_td),
    .rd_idx    (td_rd_idx),
    .rd_active (td_active),
    .rd_spd    (td_spd),
    .rd_depth  (td_depth),
    .rd_maxlen (td_maxlen),
    .rd_link   (td_link)
  );

  qw_qh_store #(.NQH(NQH), .QIW(QIW), .PW(PW)) u_qh (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_fire && cfg_kind),
    .wr_idx   (cfg_idx[QIW-1:0]),
    .wr_data  (cfg_data[2*PW-1:0]),
    .upd_en   (qh_upd_en),
    .upd_idx  (qh_rd_idx),
    .upd_vptr (qh_upd_vptr),
    .rd_idx   (qh_rd_idx),
    .rd_vptr  (qh_vptr),
    .rd_hptr  (qh_hptr)
  );

  qw_walk_fsm #(.TIW(TIW), .QIW(QIW), .LENW(LENW), .PW(PW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .start_ptr   (start_ptr),
    .budget_ok   (budget_ok),
    .busy        (busy),
    .frame_done  (frame_done),
    .exec_valid  (exec_valid),
    .exec_ready  (exec_ready),
    .exec_td     (exec_td),
    .exec_queued (exec_queued),
    .cmp_valid   (cmp_valid),
    .cmp_ready   (cmp_ready),
    .cmp_len     (cmp_len),
    .qh_rd_idx   (qh_rd_idx),
    .qh_vptr     (qh_vptr),
    .qh_hptr     (qh_hptr),
    .qh_upd_en   (qh_upd_en),
    .qh_upd_vptr (qh_upd_vptr),
    .td_rd_idx   (td_rd_idx),
    .td_active   (td_active),
    .td_spd      (td_spd),
    .td_depth    (td_depth),
    .td_maxlen   (td_maxlen),
    .td_link     (td_link),
    .td_clr_en   (td_clr_en)
  );
endmodule

// File: rtl/qw_queue_walker_chk.sv
module qw_queue_walker_chk #(
  parameter int TIW  = 4,
  parameter int LENW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_ready,
  input logic            budget_ok,
  input logic            busy,
  input logic            frame_done,
  input logic            exec_valid,
  input logic            exec_ready,
  input logic [TIW-1:0]  exec_td,
  input logic [LENW-1:0] exec_len,
  input logic            cmp_valid,
  input logic            cmp_ready
);
  AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid && !exec_ready |=> exec_valid && $stable(exec_td) && $stable(exec_len)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_valid && cmp_ready)); // R3
  AST_CMP_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready) |-> $past(exec_valid && exec_ready)); // R3
  AST_BUDGET_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_valid) |-> $past(budget_ok)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy && cfg_ready); // R2
  AST_CMP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_ready |=> !cmp_ready && !exec_valid); // R8
endmodule

bind qw_queue_walker qw_queue_walker_chk #(.TIW(TIW), .LENW(LENW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_ready  (cfg_ready),
  .budget_ok  (budget_ok),
  .busy       (busy),
  .frame_done (frame_done),
  .exec_valid (exec_valid),
  .exec_ready (exec_ready),
  .exec_td    (exec_td),
  .exec_len   (exec_len),
  .cmp_valid  (cmp_valid),
  .cmp_ready  (cmp_ready)
);

// File: tb/qw_queue_walker_tb.sv
module qw_queue_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0, cfg_kind = 1'b0;
  logic [3:0] cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic frame_start = 1'b0;
  logic [5:0] start_ptr = '0;
  logic budget_ok = 1'b1;
  logic exec_ready = 1'b0, cmp_valid = 1'b0;
  logic [6:0] cmp_len = '0;
  logic cfg_ready, busy, frame_done, exec_valid, exec_queued, cmp_ready;
  logic [3:0] exec_td;
  logic [6:0] exec_len;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int act_len [16];
  int obs [32];
  int obs_n;
  int expv [32];
  int exp_n;
  bit poke;

  localparam int MAXL = 8;
  localparam int STS = 14;

  always #2.5 clk = ~clk;

  qw_queue_walker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .frame_start(frame_start), .start_ptr(start_ptr), .budget_ok(budget_ok),
    .busy(busy), .frame_done(frame_done), .exec_valid(exec_valid),
    .exec_ready(exec_ready), .exec_td(exec_td), .exec_len(exec_len),
    .exec_queued(exec_queued), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_len(cmp_len)
  );

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected < 190000)", cyc);
      summary_and_end();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mkp(bit term, bit qh, int idx);
    return {term, qh, 4'(idx)};
  endfunction

  task automatic cfg_wr(bit kind, int idx, logic [15:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_kind = kind; cfg_idx = 4'(idx); cfg_data = d;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wr_td(int idx, bit act, bit spd, bit dep, int len, logic [5:0] link);
    cfg_wr(1'b0, idx, {act, spd, dep, 7'(len), link});
  endtask

  task automatic wr_qh(int idx, logic [5:0] v, logic [5:0] h);
    cfg_wr(1'b1, idx, {4'b0, v, h});
  endtask

  task automatic clear_all();
    for (int i = 0; i < 16; i++) begin
      wr_td(i, 1'b0, 1'b0, 1'b0, MAXL, mkp(1, 0, 0));
      act_len[i] = MAXL;
    end
    for (int i = 0; i < 4; i++) wr_qh(i, mkp(1, 0, 0), mkp(1, 0, 0));
  endtask

  // runs one frame; the engine stalls a little on each beat
  task automatic run_frame(logic [5:0] sp, int limit);
    int guard;
    obs_n = 0;
    guard = 0;
    @(negedge clk);
    start_ptr = sp;
    budget_ok = (limit > 0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    while (!frame_done && guard < 5000) begin
      guard++;
      budget_ok = (obs_n < limit);
      if (exec_valid) begin
        if (obs_n < 32) obs[obs_n] = int'(exec_td);
        chk("R3 exec_len equals requested length", int'(exec_len), MAXL);
        chk("R2 cfg_ready low while busy", int'(cfg_ready), 0);
        @(negedge clk);
        chk("R3 command held while stalled", int'(exec_valid), 1);
        exec_ready = 1'b1;
        @(negedge clk);
        exec_ready = 1'b0;
        cmp_len = 7'(act_len[obs[obs_n]]);
        obs_n++;
        @(negedge clk);
        if (poke) begin
          start_ptr = mkp(1, 0, 0);
          frame_start = 1'b1;
          @(negedge clk);
          frame_start = 1'b0;
          start_ptr = sp;
          poke = 1'b0;
        end
        cmp_valid = 1'b1;
        while (!cmp_ready) @(negedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
        budget_ok = (obs_n < limit);
      end else begin
        @(negedge clk);
      end
    end
    chk("R9 frame_done reached", int'(frame_done), 1);
    @(negedge clk);
    chk("R9 frame_done lasts one cycle", int'(frame_done), 0);
  endtask

  task automatic cmp_seq(string req);
    chk({req, " command count"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) chk({req, " command order"}, obs[i], expv[i]);
  endtask

  initial begin
    poke = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 exec_valid at reset", int'(exec_valid), 0);
    chk("R1 cmp_ready at reset", int'(cmp_ready), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 frame_done at reset", int'(frame_done), 0);
    chk("R1 cfg_ready at reset", int'(cfg_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every descriptor inactive, an empty queue head issues nothing
    run_frame(mkp(0, 1, 0), 99);
    exp_n = 0;
    cmp_seq("R1 empty schedule");

    // sweep of chain length, short position and short-detect (R3 R4 R5 R8 R9)
    for (int n = 0; n <= 5; n++) begin
      for (int sh = 0; sh <= n; sh++) begin
        for (int spd = 0; spd <= 1; spd++) begin
          clear_all();
          wr_td(0, 1, 0, 1, MAXL, (n == 0) ? mkp(1, 0, 0) : mkp(0, 0, 1));
          for (int i = 1; i <= n; i++)
            wr_td(i, 1, spd[0], 1, MAXL, (i == n) ? mkp(1, 0, 0) : mkp(0, 0, i + 1));
          wr_td(STS, 1, 0, 0, MAXL, mkp(1, 0, 0));
          wr_qh(0, mkp(0, 0, 0), mkp(0, 0, STS));
          if (sh < n) act_len[sh + 1] = 3;
          exp_n = 0;
          expv[exp_n++] = 0;
          for (int i = 1; i <= n; i++) begin
            if (spd == 1 && sh < n && i > sh + 1) break;
            expv[exp_n++] = i;
          end
          expv[exp_n++] = STS;
          run_frame(mkp(0, 1, 0), 99);
          cmp_seq((spd == 1 && sh < n) ? "R5 short ends chain" : "R4 R5 depth-first full chain");
          run_frame(mkp(0, 1, 0), 99);
          exp_n = 0;
          cmp_seq("R8 retired descriptors not reissued");
        end
      end
    end

    // budget sweep: stop after m commands, resume next frame (R7, R10)
    for (int m = 0; m <= 7; m++) begin
      int full [7];
      clear_all();
      for (int i = 0; i <= 5; i++)
        wr_td(i, 1, 1, 1, MAXL, (i == 5) ? mkp(1, 0, 0) : mkp(0, 0, i + 1));
      wr_td(STS, 1, 0, 0, MAXL, mkp(1, 0, 0));
      wr_qh(0, mkp(0, 0, 0), mkp(0, 0, STS));
      for (int i = 0; i < 6; i++) full[i] = i;
      full[6] = STS;
      poke = (m == 3);
      run_frame(mkp(0, 1, 0), m);
      exp_n = 0;
      for (int i = 0; i < m && i < 7; i++) expv[exp_n++] = full[i];
      cmp_seq(poke ? "R10 frame_start ignored while busy" : "R7 budget stop");
      run_frame(mkp(0, 1, 0), 99);
      exp_n = 0;
      for (int i = m; i < 7; i++) expv[exp_n++] = full[i];
      cmp_seq("R7 resume at first unexecuted");
    end

    // breadth mode: one vertical descriptor per visit (R4)
    clear_all();
    for (int i = 0; i <= 3; i++)
      wr_td(i, 1, 1, 0, MAXL, (i == 3) ? mkp(1, 0, 0) : mkp(0, 0, i + 1));
    wr_td(STS, 1, 0, 0, MAXL, mkp(1, 0, 0));
    wr_qh(0, mkp(0, 0, 0), mkp(0, 0, STS));
    run_frame(mkp(0, 1, 0), 99);
    exp_n = 0; expv[exp_n++] = 0; expv[exp_n++] = STS;
    cmp_seq("R4 breadth first visit");
    for (int f = 1; f <= 4; f++) begin
      run_frame(mkp(0, 1, 0), 99);
      exp_n = 0;
      if (f <= 3) expv[exp_n++] = f;
      cmp_seq("R4 breadth resumes chain");
    end

    // inactive head, queue-flagged vertical pointer, chained heads (R6 R9)
    clear_all();
    wr_td(0, 0, 0, 1, MAXL, mkp(1, 0, 0));
    wr_td(2, 1, 0, 1, MAXL, mkp(1, 0, 0));
    wr_td(5, 1, 0, 0, MAXL, mkp(0, 0, STS));
    wr_td(STS, 1, 0, 0, MAXL, mkp(1, 0, 0));
    wr_qh(0, mkp(0, 0, 0), mkp(0, 1, 1));
    wr_qh(1, mkp(0, 1, 2), mkp(0, 1, 2));
    wr_qh(2, mkp(0, 0, 2), mkp(0, 0, 5));
    run_frame(mkp(0, 1, 0), 99);
    exp_n = 0; expv[exp_n++] = 2; expv[exp_n++] = 5; expv[exp_n++] = STS;
    cmp_seq("R6 R9 skip and horizontal links");

    summary_and_end();
  end
endmodule